// File: doc/BRIEF.md
# Cache purge command sequencer

This block carries out one purge of a cache through the purge engine's 64-bit command/status register. That register is reached over a simple read/write port. A start pulse captures four caller fields: a 4-bit purge kind, a 3-bit member select, a 1-bit bank select and an 8-bit congruence-class index. The sequencer first reads the register once. If an earlier command is still pending, it stops there and writes nothing. Otherwise it writes a command word that sets the trigger bit and places the caller fields. It then reads the register repeatedly until one of three things happens: the engine reports idle, the engine reports a fault, or a poll budget runs out. A fixed delay separates each busy poll from the next one.

When the sequencer finishes, it pulses done for one cycle. It also reports a 2-bit result code, the number of polls it issued and the last status word it read. Bits in the register are numbered MSB-first, so register bit n sits on bus lane 63-n. All-zero caller fields request a flush of the whole cache.

Top module: `purge_seq`

## Requirements
- R1: After reset, bus_req_o, done_o, result_o and polls_o are all 0.
- R2: After a start, the first transaction is a read. If lane 54 (register-busy) of that read data is 1, the sequencer ends with result 1 (outstanding) and polls_o 0, and it issues no write.
- R3: The command write has lane 63 (trigger) set to 1. The purge kind goes on lanes 62:59, the member select on 46:44, the class index on 43:36 and the bank select on lane 35. Every other lane is 0.
- R4: On a poll read with lane 34 (error) set, the sequencer ends with result 2. This holds even when lane 54 is also set. polls_o then equals the index of that poll, counting from 1.
- R5: On a poll read with lanes 34 and 54 both clear, the sequencer ends with result 0. polls_o then equals the index of that poll.
- R6: If the engine is still busy on poll number MAX_POLLS, the sequencer ends with result 3 and polls_o equal to MAX_POLLS. Success on exactly poll MAX_POLLS remains result 0.
- R7: After a busy poll, the next poll read is acknowledged DELAY_CYC+1 cycles after the previous one. This assumes the port acknowledges one cycle after a request. DELAY_CYC is DELAY_NS/CLK_PERIOD_NS, rounded up.
- R8: A start pulse that arrives while a purge is in progress is ignored. Its fields do not reach the command word, and it produces no extra done.
- R9: done_o is high for exactly one cycle per purge. result_o, polls_o and status_o hold their values until the next accepted start. status_o is the last word that was read.
- R10: Once bus_req_o is raised, it stays high with bus_wr_o and bus_wdata_o unchanged until bus_ack_i. Only one transaction is outstanding at a time.
- R11: Lanes 53 and 52 (engine busy with this request, engine busy in general) never influence the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; ignored unless idle |
| kind_i | input | 4 | Purge kind field |
| member_i | input | 3 | Member select field |
| bank_i | input | 1 | Bank select field |
| cclass_i | input | 8 | Congruence-class index field |
| bus_req_o | output | 1 | Register transaction request |
| bus_wr_o | output | 1 | 1 = write, 0 = read |
| bus_wdata_o | output | 64 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge; read data valid with it |
| bus_rdata_i | input | 64 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 success, 1 outstanding, 2 error, 3 timeout |
| polls_o | output | $clog2(MAX_POLLS+1) | Number of poll reads issued |
| status_o | output | 64 | Last status word read |

## Verification
The hardest situations to reach are the ones where the engine's answer changes during a purge. These include a fault that appears on a later poll while busy is still set, and busy that lasts exactly up to the poll budget or one poll past it. The bench engine model therefore answers from a script that sets the poll index at which busy drops and the poll index at which the fault appears. The boundary runs use a small poll budget and a short delay. Every answer also sets the two side busy lanes, so R11 is checked on every run. A second start is injected in the middle of a busy run to reach the ignore path.

// File: rtl/purge_seq_pkg.sv
package purge_seq_pkg;
   localparam int WORD_W = 64;

   // register bit positions, MSB-first numbering
   localparam int TRIG_POS   = 0;
   localparam int KIND_POS   = 1;
   localparam int KIND_W     = 4;
   localparam int MEMB_POS   = 17;
   localparam int MEMB_W     = 3;
   localparam int CCLS_POS   = 20;
   localparam int CCLS_W     = 8;
   localparam int BANK_POS   = 28;
   localparam int RBUSY_POS  = 9;
   localparam int FAULT_POS  = 29;

   // bus lanes
   localparam int RBUSY_LANE = WORD_W - 1 - RBUSY_POS;
   localparam int FAULT_LANE = WORD_W - 1 - FAULT_POS;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_PENDING = 2'd1,
      RES_FAULT   = 2'd2,
      RES_TIMEOUT = 2'd3
   } result_e;

   typedef enum logic [2:0] {
      S_IDLE, S_CHECK, S_ISSUE, S_POLL, S_WAIT
   } seq_state_e;
endpackage

// File: rtl/purge_cmd_pack.sv
module purge_cmd_pack
   import purge_seq_pkg::*;
(
   input  logic [KIND_W-1:0] kind_i,
   input  logic [MEMB_W-1:0] member_i,
   input  logic              bank_i,
   input  logic [CCLS_W-1:0] cclass_i,
   output logic [WORD_W-1:0] cmd_o
);
   for (genvar k = 0; k < WORD_W; k++) begin : g_bit
      if (k == TRIG_POS) begin : g_trig
         assign cmd_o[WORD_W-1-k] = 1'b1;
      end else if (k >= KIND_POS && k < KIND_POS + KIND_W) begin : g_kind
         assign cmd_o[WORD_W-1-k] = kind_i[KIND_W-1-(k-KIND_POS)];
      end else if (k >= MEMB_POS && k < MEMB_POS + MEMB_W) begin : g_memb
         assign cmd_o[WORD_W-1-k] = member_i[MEMB_W-1-(k-MEMB_POS)];
      end else if (k >= CCLS_POS && k < CCLS_POS + CCLS_W) begin : g_ccls
         assign cmd_o[WORD_W-1-k] = cclass_i[CCLS_W-1-(k-CCLS_POS)];
      end else if (k == BANK_POS) begin : g_bank
         assign cmd_o[WORD_W-1-k] = bank_i;
      end else begin : g_zero
         assign cmd_o[WORD_W-1-k] = 1'b0;
      end
   end
endmodule

// File: rtl/purge_status_decode.sv
module purge_status_decode
   import purge_seq_pkg::*;
(
   input  logic [WORD_W-1:0] word_i,
   output logic              busy_o,
   output logic              fault_o
);
   assign busy_o  = word_i[RBUSY_LANE];
   assign fault_o = word_i[FAULT_LANE];
endmodule

// File: rtl/purge_wait_timer.sv
module purge_wait_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   if (CYCLES < 1) begin : g_bad
      $error("purge_wait_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= CW'(CYCLES - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/purge_seq.sv
module purge_seq
   import purge_seq_pkg::*;
#(
   parameter int MAX_POLLS     = 200,
   parameter int CLK_PERIOD_NS = 10,
   parameter int DELAY_NS      = 10000,
   localparam int PW           = $clog2(MAX_POLLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [3:0]        kind_i,
   input  logic [2:0]        member_i,
   input  logic              bank_i,
   input  logic [7:0]        cclass_i,
   output logic              bus_req_o,
   output logic              bus_wr_o,
   output logic [63:0]       bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [63:0]       bus_rdata_i,
   output logic              done_o,
   output logic [1:0]        result_o,
   output logic [PW-1:0]     polls_o,
   output logic [63:0]       status_o
);
   localparam int DELAY_CYC = (DELAY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

   if (MAX_POLLS < 1)     begin : g_chk_polls $error("MAX_POLLS must be >= 1");     end
   if (CLK_PERIOD_NS < 1) begin : g_chk_clk   $error("CLK_PERIOD_NS must be >= 1"); end
   if (DELAY_CYC < 1)     begin : g_chk_dly   $error("delay must be >= 1 cycle");   end

   seq_state_e        state_q;
   logic [KIND_W-1:0] kind_q;
   logic [MEMB_W-1:0] memb_q;
   logic              bank_q;
   logic [CCLS_W-1:0] ccls_q;
   logic [WORD_W-1:0] cmd_word;
   logic              rd_busy, rd_fault;
   logic              tmr_load, tmr_expire;
   logic              poll_phase;
   result_e           result_q;

   purge_cmd_pack u_pack (
      .kind_i(kind_q), .member_i(memb_q), .bank_i(bank_q),
      .cclass_i(ccls_q), .cmd_o(cmd_word)
   );

   purge_status_decode u_dec (
      .word_i(bus_rdata_i), .busy_o(rd_busy), .fault_o(rd_fault)
   );

   purge_wait_timer #(.CYCLES(DELAY_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .expire_o(tmr_expire)
   );

   assign poll_phase  = (state_q == S_POLL);
   assign bus_req_o   = (state_q == S_CHECK) || (state_q == S_ISSUE) || poll_phase;
   assign bus_wr_o    = (state_q == S_ISSUE);
   assign bus_wdata_o = bus_wr_o ? cmd_word : '0;
   assign tmr_load    = poll_phase && bus_ack_i && !rd_fault && rd_busy
                        && (polls_o < PW'(MAX_POLLS));
   assign result_o    = result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         kind_q   <= '0;
         memb_q   <= '0;
         bank_q   <= 1'b0;
         ccls_q   <= '0;
         done_o   <= 1'b0;
         result_q <= RES_OK;
         polls_o  <= '0;
         status_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            S_IDLE: if (start_i) begin
               kind_q  <= kind_i;
               memb_q  <= member_i;
               bank_q  <= bank_i;
               ccls_q  <= cclass_i;
               polls_o <= '0;
               state_q <= S_CHECK;
            end
            S_CHECK: if (bus_ack_i) begin
               status_o <= bus_rdata_i;
               if (rd_busy) begin
                  result_q <= RES_PENDING;
                  done_o   <= 1'b1;
                  state_q  <= S_IDLE;
               end else begin
                  state_q  <= S_ISSUE;
               end
            end
            S_ISSUE: if (bus_ack_i) begin
               polls_o <= PW'(1);
               state_q <= S_POLL;
            end
            S_POLL: if (bus_ack_i) begin
               status_o <= bus_rdata_i;
               if (rd_fault) begin
                  result_q <= RES_FAULT;
                  done_o   <= 1'b1;
                  state_q  <= S_IDLE;
               end else if (!rd_busy) begin
                  result_q <= RES_OK;
                  done_o   <= 1'b1;
                  state_q  <= S_IDLE;
               end else if (polls_o >= PW'(MAX_POLLS)) begin
                  result_q <= RES_TIMEOUT;
                  done_o   <= 1'b1;
                  state_q  <= S_IDLE;
               end else begin
                  state_q  <= S_WAIT;
               end
            end
            S_WAIT: if (tmr_expire) begin
               polls_o <= polls_o + 1'b1;
               state_q <= S_POLL;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/purge_seq_chk.sv
module purge_seq_chk #(
   parameter int MAX_POLLS = 200,
   parameter int PW        = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req_o,
   input logic          bus_wr_o,
   input logic [63:0]   bus_wdata_o,
   input logic          bus_ack_i,
   input logic [63:0]   bus_rdata_i,
   input logic          done_o,
   input logic [1:0]    result_o,
   input logic [PW-1:0] polls_o,
   input logic          poll_phase
);
   localparam logic [63:0] CMD_MASK = 64'hF800_7FF8_0000_0000;

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_wr_o) && $stable(bus_wdata_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && result_o == 2'd3 |-> polls_o == PW'(MAX_POLLS));

   // R2
   pending_nopoll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && result_o == 2'd1 |-> polls_o == '0);

   // R4
   fault_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_phase && bus_ack_i && bus_rdata_i[34] |=> done_o && result_o == 2'd2);

   // R5
   idle_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_phase && bus_ack_i && !bus_rdata_i[34] && !bus_rdata_i[54]
      |=> done_o && result_o == 2'd0);

   // R3
   cmd_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && bus_wr_o |-> bus_wdata_o[63] && ((bus_wdata_o & ~CMD_MASK) == 64'd0));
endmodule

bind purge_seq purge_seq_chk #(.MAX_POLLS(MAX_POLLS), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .bus_wr_o(bus_wr_o),
   .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
   .done_o(done_o), .result_o(result_o), .polls_o(polls_o), .poll_phase(poll_phase)
);

// File: tb/sim_purge_seq.sv
`timescale 1ns/1ps
module sim_purge_seq;
   localparam int MAXP = 6;
   localparam int CLKNS = 10;
   localparam int DNS = 40;
   localparam int DCYC = (DNS + CLKNS - 1) / CLKNS;
   localparam int PW = $clog2(MAXP + 1);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [3:0] kind = '0; logic [2:0] memb = '0; logic bank = 1'b0; logic [7:0] ccls = '0;
   logic req, wr, ack = 1'b0, done;
   logic [63:0] wdata, rdata = '0, status;
   logic [1:0] result; logic [PW-1:0] polls;

   purge_seq #(.MAX_POLLS(MAXP), .CLK_PERIOD_NS(CLKNS), .DELAY_NS(DNS)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind), .member_i(memb),
      .bank_i(bank), .cclass_i(ccls), .bus_req_o(req), .bus_wr_o(wr),
      .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata), .done_o(done),
      .result_o(result), .polls_o(polls), .status_o(status));

   always #5 clk = ~clk;

   int checks = 0, fails = 0;
   // engine script and observations
   int pre_busy = 0, busy_n = 0, err_at = 0;
   int cyc = 0, rd_cnt = 0, wr_cnt = 0, poll_idx = 0, last_poll = 0, gap_bad = 0;
   int done_cnt = 0, stray_done = 0;
   bit run_open = 0;
   logic [63:0] wr_word = '0, last_resp = '0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // engine model, responds one cycle after a request
   always @(negedge clk) begin
      cyc++;
      if (done) begin
         done_cnt++;
         if (!run_open) stray_done++;
      end
      if (ack) ack = 1'b0;
      else if (req) begin
         ack = 1'b1;
         if (wr) begin
            wr_cnt++;
            wr_word = wdata;
         end else begin
            logic [63:0] resp;
            rd_cnt++;
            resp = 64'h0030_0000_0000_0001; // side busy lanes 53,52 always set (R11)
            if (wr_cnt == 0) begin
               if (pre_busy != 0) resp[54] = 1'b1;
            end else begin
               poll_idx++;
               if (poll_idx <= busy_n) resp[54] = 1'b1;
               if (poll_idx == err_at) resp[34] = 1'b1;
               if (poll_idx > 1 && (cyc - last_poll) != DCYC + 1) gap_bad++;
               last_poll = cyc;
            end
            rdata = resp;
            last_resp = resp;
         end
      end
   end

   // watchdog
   always @(negedge clk) if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   function automatic logic [63:0] exp_cmd(input logic [3:0] k, input logic [2:0] m,
                                           input logic b, input logic [7:0] c);
      return {1'b1, k, 12'd0, m, c, b, 35'd0};
   endfunction

   task automatic run(input string tag, input logic [3:0] k, input logic [2:0] m,
                      input logic b, input logic [7:0] c, input int pb, input int bn,
                      input int ea, input int eres, input int epolls, input bit mid);
      int wait_n;
      @(negedge clk);
      pre_busy = pb; busy_n = bn; err_at = ea;
      rd_cnt = 0; wr_cnt = 0; poll_idx = 0; gap_bad = 0; done_cnt = 0;
      run_open = 1;
      kind = k; memb = m; bank = b; ccls = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0; kind = ~k; memb = ~m; bank = ~b; ccls = ~c;
      if (mid) begin
         repeat (6) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_n = 0;
      while (done_cnt == 0 && wait_n < 5000) begin @(negedge clk); wait_n++; end
      chk(done_cnt == 1, {tag, " R9 done seen"}, done_cnt, 1);
      chk(result == 2'(eres), {tag, " result"}, result, eres);
      chk(polls == PW'(epolls), {tag, " polls"}, polls, epolls);
      chk(status == last_resp, {tag, " R9 status"}, status, last_resp);
      chk(rd_cnt == ((eres == 1) ? 1 : epolls + 1), {tag, " R10 reads"}, rd_cnt,
          (eres == 1) ? 1 : epolls + 1);
      if (eres == 1) chk(wr_cnt == 0, {tag, " R2 no write"}, wr_cnt, 0);
      else begin
         chk(wr_cnt == 1, {tag, " R10 one write"}, wr_cnt, 1);
         chk(wr_word == exp_cmd(k, m, b, c), {tag, " R3 cmd word"}, wr_word, exp_cmd(k, m, b, c));
      end
      chk(gap_bad == 0, {tag, " R7 poll spacing"}, gap_bad, 0);
      repeat (4) @(negedge clk);
      chk(done == 1'b0 && done_cnt == 1, {tag, " R9 single pulse"}, done_cnt, 1);
      chk(result == 2'(eres) && polls == PW'(epolls), {tag, " R9 hold"}, result, eres);
      run_open = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req == 0 && done == 0 && result == 0 && polls == 0, "R1 reset", {req, done, result, polls}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req == 0 && done == 0, "R1 idle after reset", req, 0);
      run("full flush R5 R11",  4'h0, 3'h0, 1'b0, 8'h00, 0, 0, 0, 0, 1, 0);
      run("fields R3 R7",       4'hA, 3'h5, 1'b1, 8'hC3, 0, 2, 0, 0, 3, 0);
      run("pending R2",         4'h3, 3'h1, 1'b0, 8'h11, 1, 0, 0, 1, 0, 0);
      run("err while busy R4",  4'h1, 3'h2, 1'b1, 8'h5A, 0, 5, 2, 2, 2, 0);
      run("err first poll R4",  4'h0, 3'h0, 1'b0, 8'h00, 0, 0, 1, 2, 1, 0);
      run("busy to limit R6",   4'h7, 3'h7, 1'b0, 8'hFF, 0, MAXP - 1, 0, 0, MAXP, 0);
      run("timeout R6",         4'h2, 3'h3, 1'b1, 8'h80, 0, 100, 0, 3, MAXP, 0);
      run("restart ignored R8", 4'h9, 3'h4, 1'b0, 8'h3C, 0, 3, 0, 0, 4, 1);
      chk(stray_done == 0, "R8 no stray done", stray_done, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule